// File: doc/BRIEF.md
# Real-Time Clock Alarm Unit

This unit sits beside a real-time clock's time counters. Software programs a target second, minute, hour and day of month, all in packed BCD. On every one-second update strobe the unit compares those four targets with the live BCD time. If all four agree and the alarm is armed, it latches an alarm event flag.

The flag drives an active-low interrupt line, gated by an interrupt enable. A separate backup-power enable decides whether the alarm may still raise the line while the system runs from its backup supply. Reading the flags register returns the flag and clears it in the same access, so software needs no separate acknowledge. Clearing both enables disarms the alarm. The usual reprogramming sequence is: disarm, read the flags to discard a stale event, load the four targets, then re-arm.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset all four alarm targets, both enables and the alarm flag are 0, `irqN` is 1 and `busRdata` is 0.
- R2: Register offsets are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 enables and 5 flags. The four targets are 8 bits wide and read back as written. The enables register keeps the interrupt enable in bit 0 and the backup enable in bit 1, and its other bits read 0. The flags register carries the alarm flag in bit 0 and 0 in all other bits. Offsets 6 and 7 read 0.
- R3: On a clock edge with `secTick` high, the flag is set when all four targets equal `curSec`, `curMin`, `curHour` and `curDay` and at least one enable is 1.
- R4: While both enables are 0, a matching `secTick` leaves the flag at 0.
- R5: The flag is not set on a cycle without `secTick`. It is also not set on a `secTick` where any one of the four fields differs.
- R6: A read of offset 5 returns the current flag in bit 0 and clears the flag at the same edge.
- R7: If a set condition and a read of offset 5 fall on the same edge, the flag ends up 1 and the read returns the value it had before that edge.
- R8: `irqN` is 0 exactly when the flag is 1, the interrupt enable is 1, and either `backupMode` is 0 or the backup enable is 1.
- R9: A write to offset 5 neither sets nor clears the flag.
- R10: `busRdata` is loaded at the edge of a read access (`busSel` 1, `busWr` 0) and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse at each one-second time update |
| curSec | input | 8 | Live seconds, BCD |
| curMin | input | 8 | Live minutes, BCD |
| curHour | input | 8 | Live hours, BCD |
| curDay | input | 8 | Live day of month, BCD |
| backupMode | input | 1 | High while running from backup power |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqN | output | 1 | Active-low alarm interrupt |

## Verification
The hardest case to reach is a flags read that lands on the same edge as a matching one-second strobe. If the clear won, the event would be lost silently. The bench drives the read access and `secTick` in one cycle while the live time equals the targets. It expects 0 from that read and 1 from the next one. It also reaches the backup-power gating by raising `backupMode` while a flag is pending and stepping the backup enable.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ADDR_ENABLES = 4;
  localparam int ADDR_FLAGS   = 5;
  localparam int EN_INT_BIT   = 0;
  localparam int EN_BKP_BIT   = 1;
  localparam int FLAG_BIT     = 0;
  localparam int FIELDS       = 4;

  typedef struct packed {
    logic [FIELDS-1:0] wrAlarm;
    logic              wrEnables;
    logic              rdFlags;
    logic              rdStrobe;
  } strobe_t;
endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [FIELDS*DATA_W-1:0] curTime,
  output logic                     matchAll,
  output logic                     intEn,
  output logic                     backupEn,
  output logic [DATA_W-1:0]        regRdData
);
  logic [DATA_W-1:0] alarmReg [FIELDS];
  logic [FIELDS-1:0] fieldEq;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)               alarmReg[i] <= '0;
      else if (stb.wrAlarm[i]) alarmReg[i] <= wrData;
    end
    assign fieldEq[i] = (alarmReg[i] == curTime[i*DATA_W +: DATA_W]);
  end

  assign matchAll = &fieldEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      backupEn <= 1'b0;
    end else if (stb.wrEnables) begin
      intEn    <= wrData[EN_INT_BIT];
      backupEn <= wrData[EN_BKP_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    if (stb.rdStrobe && !stb.rdFlags) begin
      for (int i = 0; i < FIELDS; i++) begin
        if (rdAddr == ADDR_W'(i)) regRdData = alarmReg[i];
      end
      if (rdAddr == ADDR_W'(ADDR_ENABLES)) begin
        regRdData[EN_INT_BIT] = intEn;
        regRdData[EN_BKP_BIT] = backupEn;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              secTick,
  input  logic              backupMode,
  input  logic              matchAll,
  input  logic              intEn,
  input  logic              backupEn,
  input  logic [DATA_W-1:0] regRdData,
  output strobe_t           stb,
  output logic              alarmFlag,
  output logic              irqN,
  output logic [DATA_W-1:0] busRdata
);
  logic armed;
  logic setNow;
  logic [DATA_W-1:0] flagsWord;

  always_comb begin
    stb = '0;
    for (int i = 0; i < FIELDS; i++)
      stb.wrAlarm[i] = busSel && busWr && (busAddr == ADDR_W'(i));
    stb.wrEnables = busSel && busWr && (busAddr == ADDR_W'(ADDR_ENABLES));
    stb.rdStrobe  = busSel && !busWr;
    stb.rdFlags   = busSel && !busWr && (busAddr == ADDR_W'(ADDR_FLAGS));
  end

  assign armed  = intEn || backupEn;
  assign setNow = secTick && matchAll && armed;

  always_ff @(posedge clk) begin
    if (!rstN)            alarmFlag <= 1'b0;
    else if (setNow)      alarmFlag <= 1'b1;
    else if (stb.rdFlags) alarmFlag <= 1'b0;
  end

  always_comb begin
    flagsWord = '0;
    flagsWord[FLAG_BIT] = alarmFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdata <= '0;
    else if (stb.rdStrobe) busRdata <= stb.rdFlags ? flagsWord : regRdData;
  end

  assign irqN = !(alarmFlag && intEn && (!backupMode || backupEn));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  input  logic              backupMode,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqN
);
  localparam int TIME_W = FIELDS * DATA_W;

  strobe_t           stb;
  logic              matchAll;
  logic              intEn;
  logic              backupEn;
  logic              alarmFlag;
  logic [DATA_W-1:0] regRdData;
  logic [TIME_W-1:0] curTime;

  assign curTime = {curDay, curHour, curMin, curSec};

  rtc_alarm_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata), .rdAddr(busAddr),
    .curTime(curTime), .matchAll(matchAll), .intEn(intEn),
    .backupEn(backupEn), .regRdData(regRdData)
  );

  rtc_alarm_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .secTick(secTick), .backupMode(backupMode), .matchAll(matchAll),
    .intEn(intEn), .backupEn(backupEn), .regRdData(regRdData), .stb(stb),
    .alarmFlag(alarmFlag), .irqN(irqN), .busRdata(busRdata)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              backupMode,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqN,
  input logic              alarmFlag,
  input logic              intEn,
  input logic              backupEn,
  input logic              matchAll
);
  logic rdFl, wrFl;
  assign rdFl = busSel && !busWr && (busAddr == ADDR_W'(ADDR_FLAGS));
  assign wrFl = busSel && busWr && (busAddr == ADDR_W'(ADDR_FLAGS));

  a_r3_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && matchAll && (intEn || backupEn)) |=> alarmFlag);
  a_r4_disarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && !intEn && !backupEn) |=> !alarmFlag);
  a_r5_no_tick_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && !secTick) |=> !alarmFlag);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdFl && !secTick) |=> !alarmFlag);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (rdFl && secTick && matchAll && (intEn || backupEn)) |=> alarmFlag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag || !intEn) |-> irqN);
  a_r8_backup_gate: assert property (@(posedge clk) disable iff (!rstN)
    (backupMode && !backupEn) |-> irqN);
  a_r9_flag_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrFl && !secTick) |=> $stable(alarmFlag));
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> $stable(busRdata));
endmodule

bind rtc_alarm_unit rtc_alarm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .secTick(secTick), .backupMode(backupMode),
  .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busRdata(busRdata),
  .irqN(irqN), .alarmFlag(alarmFlag), .intEn(intEn), .backupEn(backupEn),
  .matchAll(matchAll)
);

// File: tb/rtc_alarm_unit_tb_top.sv
module rtc_alarm_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, secTick = 0, backupMode = 0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0, curDay = 0;
  logic busSel = 0, busWr = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic irqN;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic rdLat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_unit dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDay(curDay), .backupMode(backupMode), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqN(irqN)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdLat <= busSel && !busWr;

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rdLat) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected read actual=%h expected=none", busRdata);
      end else begin
        check(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [7:0] exp,
                         input string tag, input bit withTick);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busSel = 1; busWr = 0; busAddr = a; secTick = withTick;
    @(negedge clk); busSel = 0; secTick = 0;
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, d);
    curSec = s; curMin = m; curHour = h; curDay = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1 irqN after reset", {7'b0, irqN}, 8'h01);
    for (int a = 0; a < 6; a++) busRead(3'(a), 8'h00, "R1 reset readback", 0);

    // R4: program targets with both enables cleared, matching tick
    busWrite(3'd0, 8'h56); busWrite(3'd1, 8'h34);
    busWrite(3'd2, 8'h12); busWrite(3'd3, 8'h15);
    setTime(8'h56, 8'h34, 8'h12, 8'h15);
    tick(); tick();
    check("R4 irqN disarmed", {7'b0, irqN}, 8'h01);
    busRead(3'd5, 8'h00, "R4 flag stays clear", 0);

    // R2: readback of targets, enables mask, unused offsets
    busRead(3'd0, 8'h56, "R2 sec", 0);
    busRead(3'd1, 8'h34, "R2 min", 0);
    busRead(3'd2, 8'h12, "R2 hour", 0);
    busRead(3'd3, 8'h15, "R2 day", 0);
    busWrite(3'd4, 8'hFF);
    busRead(3'd4, 8'h03, "R2 enables mask", 0);
    busRead(3'd6, 8'h00, "R2 unused offset", 0);
    busWrite(3'd4, 8'h01);

    // R5: one field differs, and matching time without tick
    setTime(8'h56, 8'h35, 8'h12, 8'h15);
    tick();
    busRead(3'd5, 8'h00, "R5 minute mismatch", 0);
    setTime(8'h56, 8'h34, 8'h12, 8'h16);
    tick();
    busRead(3'd5, 8'h00, "R5 day mismatch", 0);
    setTime(8'h56, 8'h34, 8'h12, 8'h15);
    repeat (5) @(negedge clk);
    busRead(3'd5, 8'h00, "R5 no tick", 0);

    // R3 / R8: match sets flag, interrupt asserts
    tick();
    setTime(8'h00, 8'h34, 8'h12, 8'h15);
    check("R8 irqN low on flag", {7'b0, irqN}, 8'h00);
    busRead(3'd5, 8'h01, "R3 flag set by match", 0);
    // R6: read cleared it
    check("R6 irqN released by read", {7'b0, irqN}, 8'h01);
    busRead(3'd5, 8'h00, "R6 flag cleared", 0);

    // R8: enable gating and backup gating
    setTime(8'h56, 8'h34, 8'h12, 8'h15);
    tick();
    setTime(8'h00, 8'h34, 8'h12, 8'h15);
    busWrite(3'd4, 8'h00);
    check("R8 irqN off with int enable clear", {7'b0, irqN}, 8'h01);
    busWrite(3'd4, 8'h01);
    check("R8 irqN on again", {7'b0, irqN}, 8'h00);
    @(negedge clk); backupMode = 1; #1;
    check("R8 backup without backup enable", {7'b0, irqN}, 8'h01);
    busWrite(3'd4, 8'h03);
    check("R8 backup with backup enable", {7'b0, irqN}, 8'h00);

    // R9: write to flags has no effect
    busWrite(3'd5, 8'h00);
    check("R9 irqN after flag write", {7'b0, irqN}, 8'h00);
    busRead(3'd5, 8'h01, "R9 flag survives write", 0);
    busWrite(3'd5, 8'hFF);
    busRead(3'd5, 8'h00, "R9 write cannot set flag", 0);
    @(negedge clk); backupMode = 0;

    // R7: read and matching tick on the same edge
    setTime(8'h56, 8'h34, 8'h12, 8'h15);
    busRead(3'd5, 8'h00, "R7 read sees prior value", 1);
    setTime(8'h00, 8'h34, 8'h12, 8'h15);
    busRead(3'd5, 8'h01, "R7 set wins over clear", 0);

    // R10: read data holds without access
    repeat (4) @(negedge clk);
    check("R10 rdata holds", busRdata, 8'h01);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10 pending reads actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule